// File: doc/BRIEF.md
# Table-Fed Sequential Shift-Add Multiplier

This block multiplies two unsigned 4-bit operands by repeated add-and-shift and returns an 8-bit product. It does not take the operands on ports. A 5-bit index picks an operand pair from a constant 32-entry, 4-bit-wide table that is built into the block. The lower half of the table holds multiplicands and the upper half holds multipliers. The multiplicand is read at the index, and the multiplier is read at the index plus 16, modulo 32.

An algorithmic state machine sequences the work. It has five states: waiting, testing the low multiplier bit, adding, shifting and finishing. The datapath holds a 5-bit accumulator, a multiplier shift register, a captured multiplicand and a step counter. Each shift moves the low accumulator bit into the top of the multiplier register. After the last shift the two registers together hold the full product. A caller pulses start with an index, waits for the one-cycle done pulse, and then reads the product. The product stays valid until the next run completes.

Top module: `rom_shift_multiplier`

## Requirements
- R1: Table entry e holds (5*e+3) mod 16 for e in 0..15 and (7*(e-16)+2) mod 16 for e in 16..31. For index a, the multiplicand is entry a and the multiplier is entry (a+16) mod 32.
- R2: After a run started with index a, product equals multiplicand times multiplier as an unsigned 8-bit value. This also holds for back-to-back runs, because the accumulator is cleared on every accepted start.
- R3: A start sampled high in the waiting state is accepted. The controller then spends one test cycle per bit, one add cycle for each 1 bit of the multiplier, and one shift cycle per bit. As a result, done is high in the cycle that begins 8 + popcount(multiplier) rising edges after the edge that accepted start.
- R4: done is high for exactly one clock cycle per run.
- R5: start is ignored in every state other than waiting, including the done cycle. Such a start causes no extra done pulse and does not change the product or the timing of the current run.
- R6: Both operands are captured when start is accepted. Changing the index during a run has no effect on that run's result.
- R7: product changes only in the cycle where done is high. It holds its value through a following run until that run completes.
- R8: Reset is asynchronous and active high. It forces done to 0 and product to 0 and returns the controller to waiting, including in the middle of a run.
- R9: A zero multiplier produces no add cycles. The product is 0 and done comes 8 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| start | input | 1 | Request to begin a multiplication, sampled only while waiting |
| addr | input | 5 | Operand pair index into the constant table |
| product | output | 8 | Registered result of the last completed run |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can meet in the same cycle: completion of a run and a fresh start request. The completion is the done cycle that loads the product, and the start request is one the caller issues as soon as it sees done. The bench provokes this by driving start, with a different index, in exactly the cycle where done is high. It then requires that no further done pulse appears and that the product stays at the finished result. A second collision is a start pulse with a changed index in the middle of a run. The scoreboard judges this by the unchanged result and latency of the run in progress.

// File: rtl/msa_pkg.sv
package msa_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CHECK = 3'd1,
      ST_ADD   = 3'd2,
      ST_SHIFT = 3'd3,
      ST_DONE  = 3'd4
   } msa_state_e;

endpackage

// File: rtl/msa_operand_rom.sv
module msa_operand_rom #(
   parameter int OP_W   = 4,
   parameter int ADDR_W = 5,
   parameter int MC_MUL = 5,
   parameter int MC_OFS = 3,
   parameter int MP_MUL = 7,
   parameter int MP_OFS = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [OP_W-1:0]   mcand,
   output logic [OP_W-1:0]   mplr
);
   localparam int DEPTH = 2 ** ADDR_W;
   localparam int HALF  = DEPTH / 2;
   localparam int VMOD  = 2 ** OP_W;

   logic [OP_W-1:0]   tbl [DEPTH];
   logic [ADDR_W-1:0] mp_idx;

   // Constant contents: one affine sequence per half
   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      if (e < HALF) begin : g_lo
         localparam int VAL = (MC_MUL * e + MC_OFS) % VMOD;
         assign tbl[e] = OP_W'(VAL);
      end else begin : g_hi
         localparam int VAL = (MP_MUL * (e - HALF) + MP_OFS) % VMOD;
         assign tbl[e] = OP_W'(VAL);
      end
   end

   assign mp_idx = addr + ADDR_W'(HALF);
   assign mcand  = tbl[addr];
   assign mplr   = tbl[mp_idx];
endmodule

// File: rtl/msa_ctrl.sv
module msa_ctrl
   import msa_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic       lsb,
   input  logic       last_step,
   output msa_state_e state,
   output logic       load,
   output logic       add_en,
   output logic       shift_en,
   output logic       done
);
   msa_state_e nxt;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) state <= ST_IDLE;
      else     state <= nxt;
   end

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (start) nxt = ST_CHECK;
         ST_CHECK: nxt = lsb ? ST_ADD : ST_SHIFT;
         ST_ADD:   nxt = ST_SHIFT;
         ST_SHIFT: nxt = last_step ? ST_DONE : ST_CHECK;
         ST_DONE:  nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   assign load     = (state == ST_IDLE) && start;
   assign add_en   = (state == ST_ADD);
   assign shift_en = (state == ST_SHIFT);
   assign done     = (state == ST_DONE);
endmodule

// File: rtl/msa_datapath.sv
module msa_datapath #(
   parameter int OP_W = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic            add_en,
   input  logic            shift_en,
   input  logic [OP_W-1:0] mcand_in,
   input  logic [OP_W-1:0] mplr_in,
   output logic            lsb,
   output logic            last_step,
   output logic [2*OP_W-1:0] product
);
   localparam int CNT_W  = $clog2(OP_W + 1);
   localparam int PROD_W = 2 * OP_W;

   logic [OP_W:0]      acc;
   logic [OP_W-1:0]    mq;
   logic [OP_W-1:0]    mc_q;
   logic [CNT_W-1:0]   cnt;
   logic [PROD_W-1:0]  prod_q;
   logic [OP_W:0]      sum;

   assign sum       = acc + {1'b0, mc_q};
   assign lsb       = mq[0];
   assign last_step = (cnt == CNT_W'(1));

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         acc  <= '0;
         mq   <= '0;
         mc_q <= '0;
         cnt  <= '0;
      end else if (load) begin
         acc  <= '0;
         mq   <= mplr_in;
         mc_q <= mcand_in;
         cnt  <= CNT_W'(OP_W);
      end else if (add_en) begin
         acc  <= sum;
      end else if (shift_en) begin
         acc  <= acc >> 1;
         mq   <= {acc[0], mq[OP_W-1:1]};
         cnt  <= cnt - CNT_W'(1);
      end
   end

   // Result register: loaded by the final shift, i.e. on entry to done
   always_ff @(posedge clk or posedge rst) begin
      if (rst)                        prod_q <= '0;
      else if (shift_en && last_step) prod_q <= {acc, mq[OP_W-1:1]};
   end

   assign product = prod_q;
endmodule

// File: rtl/rom_shift_multiplier.sv
module rom_shift_multiplier
   import msa_pkg::*;
#(
   parameter int OP_W   = 4,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   output logic [2*OP_W-1:0] product,
   output logic              done
);
   if (OP_W < 2) begin : g_bad_opw
      $error("OP_W must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addrw
      $error("ADDR_W must be at least 1");
   end

   msa_state_e      state_q;
   logic            load, add_en, shift_en, lsb, last_step;
   logic [OP_W-1:0] mcand, mplr;

   msa_operand_rom #(.OP_W(OP_W), .ADDR_W(ADDR_W)) u_rom (
      .addr  (addr),
      .mcand (mcand),
      .mplr  (mplr)
   );

   msa_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .lsb       (lsb),
      .last_step (last_step),
      .state     (state_q),
      .load      (load),
      .add_en    (add_en),
      .shift_en  (shift_en),
      .done      (done)
   );

   msa_datapath #(.OP_W(OP_W)) u_dp (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .add_en    (add_en),
      .shift_en  (shift_en),
      .mcand_in  (mcand),
      .mplr_in   (mplr),
      .lsb       (lsb),
      .last_step (last_step),
      .product   (product)
   );
endmodule

// File: rtl/msa_checker.sv
module msa_checker
   import msa_pkg::*;
#(
   parameter int OP_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic              done,
   input logic [2*OP_W-1:0] product,
   input msa_state_e        state
);
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R4

   AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !$stable(product) |-> done); // R7

   AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE && start) |=> (state == ST_CHECK)); // R3

   AST_ADD_THEN_SHIFT: assert property (@(posedge clk) disable iff (rst)
      (state == ST_ADD) |=> (state == ST_SHIFT)); // R3

   AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
      (state != ST_IDLE && state != ST_SHIFT) |=> (state != ST_CHECK)); // R5

   AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DONE) |=> (state == ST_IDLE)); // R5
endmodule

bind rom_shift_multiplier msa_checker #(.OP_W(OP_W)) u_msa_chk (
   .clk     (clk),
   .rst     (rst),
   .start   (start),
   .done    (done),
   .product (product),
   .state   (state_q)
);

// File: tb/rom_shift_multiplier_tb.sv
module rom_shift_multiplier_tb;
   typedef struct {
      logic [7:0] prod;
      int         due;
      bit         zero_mp;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [4:0] addr = '0;
   logic [7:0] product;
   logic       done;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   prev_done = 1'b0;
   logic [7:0] held = '0;
   exp_t sb[$];

   rom_shift_multiplier u_dut (
      .clk(clk), .rst(rst), .start(start), .addr(addr),
      .product(product), .done(done)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [3:0] tbl(input int e);
      if (e < 16) return 4'((5 * e + 3) % 16);
      return 4'((7 * (e - 16) + 2) % 16);
   endfunction

   function automatic int pop4(input logic [3:0] v);
      return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // Monitor: pops the scoreboard on every done pulse
   always @(negedge clk) begin
      if (!rst) begin
         if (done) begin
            check(!prev_done, "R4 done longer than one cycle", 1, 0);
            if (sb.size() == 0) begin
               check(1'b0, "R5 unexpected done", 1, 0);
            end else begin
               exp_t it;
               it = sb.pop_front();
               check(product == it.prod, it.zero_mp ? "R9 zero multiplier product" : "R1 R2 product",
                     int'(product), int'(it.prod));
               check(cyc == it.due, it.zero_mp ? "R9 zero multiplier latency" : "R3 latency",
                     cyc, it.due);
            end
         end
         prev_done = done;
      end else begin
         prev_done = 1'b0;
      end
   end

   // Driver: starts a run and pushes its expected result
   task automatic launch(input logic [4:0] a, input bit noisy);
      exp_t it;
      logic [3:0] mc, mp;
      wait (sb.size() == 0);
      @(negedge clk);
      mc = tbl(int'(a));
      mp = tbl(int'(5'(a + 5'd16)));
      it.prod    = 8'(mc) * 8'(mp);
      it.due     = cyc + 1 + 8 + pop4(mp);
      it.zero_mp = (mp == 4'd0);
      addr  = a;
      start = 1'b1;
      sb.push_back(it);
      @(negedge clk);
      start = 1'b0;
      if (noisy) begin
         addr = ~a;  // R6: index change mid-run
         repeat (2) @(negedge clk);
         check(product == held, "R7 product held during run", int'(product), int'(held));
         start = 1'b1;  // R5: ignored start
         @(negedge clk);
         start = 1'b0;
      end
      held = it.prod;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R8 reset done", int'(done), 0);
      check(product == 8'd0, "R8 reset product", int'(product), 0);
      rst = 1'b0;
      @(negedge clk);
      check(done == 1'b0 && product == 8'd0, "R8 idle after reset", int'(product), 0);

      // All indices, including wrap-around of the upper half (R1, R2, R3, R9)
      for (int a = 0; a < 32; a++) launch(5'(a), 1'b0);

      // Start pulses and index changes mid-run (R5, R6, R7)
      launch(5'd7, 1'b1);
      launch(5'd12, 1'b1);
      launch(5'd2, 1'b1);

      // Start in the done cycle collides with completion (R5, R7)
      launch(5'd5, 1'b0);
      while (!done) @(negedge clk);
      addr  = 5'd9;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (14) @(negedge clk);
      check(product == held, "R5 start in done cycle ignored", int'(product), int'(held));

      // Asynchronous reset mid-run (R8)
      launch(5'd13, 1'b0);
      repeat (4) @(negedge clk);
      rst = 1'b1;
      #1;
      check(done == 1'b0, "R8 async reset done", int'(done), 0);
      check(product == 8'd0, "R8 async reset product", int'(product), 0);
      sb.delete();
      held = 8'd0;
      @(negedge clk);
      rst = 1'b0;
      repeat (12) @(negedge clk);
      check(product == 8'd0, "R8 no completion after reset", int'(product), 0);

      launch(5'd15, 1'b0);
      launch(5'd15, 1'b0);
      wait (sb.size() == 0);
      repeat (3) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule